// File: doc/BRIEF.md
# Dithered Comparator Oversampling Estimator

This block turns a stream of single-bit decisions from a threshold comparator into a multi-bit voltage estimate. The comparator input carries uniform random dither that spans a known width centred on the signal. Over a window of programmable length the block counts how many strobed samples came out one and how many came out zero. When the window closes it works out what fraction of the samples landed above the threshold and scales that fraction by the dither span. Adding the threshold gives the top edge of the dither range, and subtracting half the span gives the estimated input, in millivolts.

The control is a three-state machine. In `ST_COLLECT` the counters accept samples. The sample that completes the window takes the transition *close* to `ST_DIVIDE`. There the product (one-count × span) is divided by the total count in a restoring divider that produces one quotient bit per clock. When the divider reports completion, the transition *finish* moves to `ST_PUBLISH`. In that cycle the estimate is presented with a one-cycle valid pulse and the counters are cleared. The unconditional transition *restart* then returns to `ST_COLLECT` on the next clock. Synchronous reset forces `ST_COLLECT` from any state.

Top module: `dither_ratio_estimator`

## Requirements
- R1: While `rst` is high and after it falls, `est_valid` is 0 and `est_mv` is 0, and the next window starts with both counts at zero.
- R2: In `ST_COLLECT`, a cycle with `sample_en` high adds one to the one-count if `cmp_bit` is 1 and adds one to the zero-count if `cmp_bit` is 0. A cycle with `sample_en` low changes neither count.
- R3: The window closes on the accepted sample that makes the one-count plus zero-count reach `window_len`. A `window_len` of 0 behaves as 1.
- R4: The published estimate is thresh + floor(N1 × span / (N1 + N0)) − floor(span / 2). It is carried on 17 bits, so results up to 131070 are exact.
- R5: If that expression is negative, `est_mv` is 0.
- R6: With threshold 500, span 500, N1 = 11 and N0 = 32, the estimate is 377.
- R7: `est_valid` is high for exactly one cycle. It is seen in the 33rd cycle after the clock edge that accepted the closing sample. `est_mv` keeps its value until the next publish.
- R8: Samples strobed in `ST_DIVIDE` or `ST_PUBLISH` are ignored. The first sample counted in the next window is the one accepted at the edge that ends the valid cycle's following cycle, which is the second edge after `est_valid` rises.
- R9: `thresh_mv` and `span_mv` are sampled at the edge that accepts the closing sample. Later changes do not affect that window's estimate.
- R10: A reset asserted during `ST_DIVIDE` abandons the window: no valid pulse follows and `est_mv` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_en | input | 1 | Strobe: take `cmp_bit` this cycle |
| cmp_bit | input | 1 | Comparator decision, 1 when the dithered input is at or above the threshold |
| window_len | input | 16 | Number of samples per window |
| thresh_mv | input | 16 | Comparator threshold in mV |
| span_mv | input | 16 | Full width of the dither range in mV |
| est_mv | output | 17 | Estimated input voltage in mV |
| est_valid | output | 1 | One-cycle pulse when `est_mv` is updated |

## Verification
The bench targets several edges:
- **All-zero window.** It drives the estimate below zero, so a design that computes the subtraction without clamping would publish a wrapped value near 2^17 instead of 0.
- **Window lengths of 1 and 0.** These exercise the close comparison. An off-by-one design would wait for an extra sample, and a design that does not treat zero as one would hang.
- **Traffic during the divide and rounding.** Ones are strobed while the divider runs, and the threshold and span are changed right after the window closes. A design that kept counting or read the live inputs would publish a shifted result. The worked example and a full-scale case check the truncating divide and the 17-bit sum.
- **Reset during the divide.** A reset in the middle of the divide must produce no stray valid pulse.

// File: rtl/dre_pkg.sv
package dre_pkg;

    typedef enum logic [1:0] {
        ST_COLLECT = 2'd0,
        ST_DIVIDE  = 2'd1,
        ST_PUBLISH = 2'd2
    } dre_state_e;

endpackage

// File: rtl/dre_sample_counter.sv
module dre_sample_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          accept,
    input  logic          bit_in,
    output logic [CW-1:0] ones,
    output logic [CW-1:0] zeros,
    output logic [CW-1:0] ones_next,
    output logic [CW:0]   total_next
);

    logic [CW-1:0] zeros_next;

    always_comb begin
        ones_next  = ones  + CW'(accept &  bit_in);
        zeros_next = zeros + CW'(accept & ~bit_in);
        total_next = {1'b0, ones_next} + {1'b0, zeros_next};
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            ones  <= '0;
            zeros <= '0;
        end else begin
            ones  <= ones_next;
            zeros <= zeros_next;
        end
    end

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!clear && !accept) |=> ($stable(ones) && $stable(zeros)));

    // R2
    one_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!clear && accept && bit_in) |=> ($stable(zeros) && ones != $past(ones)));

endmodule

// File: rtl/dre_restoring_divider.sv
module dre_restoring_divider #(
    parameter int NW = 32,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [NW-1:0] dividend,
    input  logic [DW-1:0] divisor,
    output logic [NW-1:0] quotient,
    output logic          busy,
    output logic          done
);

    localparam int CNTW = $clog2(NW);
    localparam logic [CNTW-1:0] LAST = CNTW'(NW - 1);

    logic [NW-1:0]   work;
    logic [DW:0]     rem;
    logic [DW-1:0]   dsr;
    logic [CNTW-1:0] cnt;
    logic [DW:0]     trial;
    logic            fits;

    always_comb begin
        trial = {rem[DW-1:0], work[NW-1]};
        fits  = (trial >= {1'b0, dsr});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            work <= '0;
            rem  <= '0;
            dsr  <= '0;
            cnt  <= '0;
            busy <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                work <= dividend;
                rem  <= '0;
                dsr  <= divisor;
                cnt  <= '0;
                busy <= 1'b1;
            end else if (busy) begin
                if (fits) begin
                    rem  <= trial - {1'b0, dsr};
                    work <= {work[NW-2:0], 1'b1};
                end else begin
                    rem  <= trial;
                    work <= {work[NW-2:0], 1'b0};
                end
                cnt <= cnt + 1'b1;
                if (cnt == LAST) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assign quotient = work;

    // R7
    div_done_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !start && cnt == LAST) |=> (done && !busy));

    // R4
    div_remainder_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (rem < {1'b0, dsr}));

endmodule

// File: rtl/dither_ratio_estimator.sv
module dither_ratio_estimator #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sample_en,
    input  logic         cmp_bit,
    input  logic [15:0]  window_len,
    input  logic [15:0]  thresh_mv,
    input  logic [15:0]  span_mv,
    output logic [16:0]  est_mv,
    output logic         est_valid
);
    import dre_pkg::*;

    localparam int PW = 2 * W;
    localparam int EW = W + 1;

    dre_state_e state, state_nx;

    logic          accept, clear, close;
    logic [W-1:0]  ones, zeros, ones_next;
    logic [W:0]    total_next, len_eff;
    logic [PW-1:0] product, quo;
    logic          div_busy, div_done;
    logic [W-1:0]  thresh_q, half_q;
    logic [EW-1:0] sum, est_calc;

    always_comb begin
        accept  = (state == ST_COLLECT) && sample_en;
        clear   = (state == ST_PUBLISH);
        len_eff = (window_len[W-1:0] == '0) ? EW'(1) : {1'b0, window_len[W-1:0]};
        close   = accept && (total_next >= len_eff);
        product = PW'(ones_next) * PW'(span_mv[W-1:0]);
    end

    dre_sample_counter #(.CW(W)) u_count (
        .clk        (clk),
        .rst        (rst),
        .clear      (clear),
        .accept     (accept),
        .bit_in     (cmp_bit),
        .ones       (ones),
        .zeros      (zeros),
        .ones_next  (ones_next),
        .total_next (total_next)
    );

    dre_restoring_divider #(.NW(PW), .DW(W)) u_div (
        .clk      (clk),
        .rst      (rst),
        .start    (close),
        .dividend (product),
        .divisor  (total_next[W-1:0]),
        .quotient (quo),
        .busy     (div_busy),
        .done     (div_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            thresh_q <= '0;
            half_q   <= '0;
        end else if (close) begin
            thresh_q <= thresh_mv[W-1:0];
            half_q   <= span_mv[W-1:0] >> 1;
        end
    end

    always_comb begin
        sum      = {1'b0, thresh_q} + {1'b0, quo[W-1:0]};
        est_calc = (sum >= {1'b0, half_q}) ? (sum - {1'b0, half_q}) : '0;
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_COLLECT;
        else     state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_COLLECT: if (close)    state_nx = ST_DIVIDE;
            ST_DIVIDE:  if (div_done) state_nx = ST_PUBLISH;
            ST_PUBLISH:               state_nx = ST_COLLECT;
            default:                  state_nx = ST_COLLECT;
        endcase
    end

    // outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            est_mv    <= '0;
            est_valid <= 1'b0;
        end else begin
            est_valid <= 1'b0;
            if (state == ST_DIVIDE && div_done) begin
                est_mv    <= est_calc;
                est_valid <= 1'b1;
            end
        end
    end

    // R7
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        est_valid |=> !est_valid);

    // R8
    divide_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DIVIDE) |=> ($stable(ones) && $stable(zeros)));

    // R8
    divide_live_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DIVIDE) |-> (div_busy || div_done));

    // R4
    quot_fit_chk: assert property (@(posedge clk) disable iff (rst)
        div_done |-> (quo[PW-1:W] == '0));

    // R5
    floor_chk: assert property (@(posedge clk) disable iff (rst)
        est_valid |-> ((est_mv == '0) || (est_mv + {1'b0, half_q} >= {1'b0, thresh_q})));

endmodule

// File: tb/dither_ratio_estimator_bench.sv
`timescale 1ns/1ps
module dither_ratio_estimator_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sample_en = 1'b0;
    logic        cmp_bit = 1'b0;
    logic [15:0] window_len = 16'd1;
    logic [15:0] thresh_mv = '0;
    logic [15:0] span_mv = '0;
    logic [16:0] est_mv;
    logic        est_valid;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    dither_ratio_estimator u_dither_ratio_estimator (
        .clk        (clk),
        .rst        (rst),
        .sample_en  (sample_en),
        .cmp_bit    (cmp_bit),
        .window_len (window_len),
        .thresh_mv  (thresh_mv),
        .span_mv    (span_mv),
        .est_mv     (est_mv),
        .est_valid  (est_valid)
    );

    function automatic int exp_est(int th, int sp, int n1, int n0);
        int s;
        s = th + (n1 * sp) / (n1 + n0) - sp / 2;
        return (s < 0) ? 0 : s;
    endfunction

    task automatic chk(bit ok, string tag, int act, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // behavioural reference, advanced on every clock
    int m_n1 = 0, m_n0 = 0, m_phase = 0, m_wait = 0, m_est = 0, m_pend = 0;
    bit m_valid = 0, m_started = 0;
    int m_len;

    always @(posedge clk) begin
        m_started = 1;
        if (rst) begin
            m_n1 = 0; m_n0 = 0; m_phase = 0; m_wait = 0;
            m_est = 0; m_valid = 0;
        end else begin
            m_valid = 0;
            if (m_phase == 0) begin
                if (sample_en) begin
                    if (cmp_bit) m_n1++; else m_n0++;
                    m_len = (window_len == 0) ? 1 : int'(window_len);
                    if (m_n1 + m_n0 >= m_len) begin
                        m_pend  = exp_est(int'(thresh_mv), int'(span_mv), m_n1, m_n0);
                        m_phase = 1;
                        m_wait  = 0;
                    end
                end
            end else begin
                m_wait++;
                if (m_wait == 33) begin
                    m_valid = 1;
                    m_est   = m_pend;
                end
                if (m_wait == 34) begin
                    m_phase = 0; m_n1 = 0; m_n0 = 0;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (m_started) begin
            chk(est_valid == m_valid, "R7 est_valid vs model", int'(est_valid), int'(m_valid));
            chk(int'(est_mv) == m_est, "R4 est_mv vs model", int'(est_mv), m_est);
        end
    end

    // feed one window; returns published value and negedges from last sample to valid
    task automatic feed(int len, int th, int sp, int n1, int n0, bit gap,
                        bit alter, bit busy_ones, output int est_out, output int lat);
        int tot;
        bit b;
        tot = n1 + n0;
        window_len = 16'(len);
        thresh_mv  = 16'(th);
        span_mv    = 16'(sp);
        for (int i = 0; i < tot; i++) begin
            @(negedge clk);
            b = (((i + 1) * n1) / tot) != ((i * n1) / tot);
            sample_en = 1'b1;
            cmp_bit   = b;
            if (gap && i != tot - 1) begin
                @(negedge clk);
                sample_en = 1'b0;
                cmp_bit   = ~b;
            end
        end
        lat = 0;
        est_out = -1;
        for (int k = 1; k <= 200; k++) begin
            @(negedge clk);
            sample_en = busy_ones;
            cmp_bit   = busy_ones;
            if (alter) begin
                thresh_mv = 16'd9999;
                span_mv   = 16'd0;
            end
            if (est_valid) begin
                lat = k;
                est_out = int'(est_mv);
                break;
            end
        end
        if (lat == 0) chk(0, "R7 valid timeout", 0, 1);
        @(negedge clk);
        sample_en = 1'b0;
        cmp_bit   = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int e, l;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(est_valid == 1'b0, "R1 valid in reset", int'(est_valid), 0);
        chk(est_mv == '0, "R1 est in reset", int'(est_mv), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(est_valid == 1'b0 && est_mv == '0, "R1 after reset", int'(est_mv), 0);

        // R6 worked example, R7 latency
        feed(43, 500, 500, 11, 32, 0, 0, 0, e, l);
        chk(e == 377, "R6 example estimate", e, 377);
        chk(l == 34, "R7 latency", l, 34);
        chk(est_valid == 1'b0, "R7 single pulse", int'(est_valid), 0);
        chk(int'(est_mv) == 377, "R7 value held", int'(est_mv), 377);

        // R2 gapped strobes with flipped idle bit
        feed(10, 1000, 200, 3, 7, 1, 0, 0, e, l);
        chk(e == 960, "R2 gapped window", e, 960);

        // R5 clamp
        feed(8, 100, 1000, 0, 8, 0, 0, 0, e, l);
        chk(e == 0, "R5 clamp to zero", e, 0);

        // R4 all ones and full scale
        feed(5, 0, 1000, 5, 0, 0, 0, 0, e, l);
        chk(e == 500, "R4 all ones", e, 500);
        feed(5, 65535, 65535, 5, 0, 0, 0, 0, e, l);
        chk(e == 98303, "R4 full scale 17 bit", e, 98303);

        // R3 length one and zero
        feed(1, 300, 40, 1, 0, 0, 0, 0, e, l);
        chk(e == 320, "R3 length one", e, 320);
        feed(0, 300, 40, 0, 1, 0, 0, 0, e, l);
        chk(e == 280, "R3 length zero", e, 280);

        // R8 ones strobed during divide are ignored
        feed(4, 200, 100, 4, 0, 0, 0, 1, e, l);
        chk(e == 250, "R8 first window", e, 250);
        feed(4, 200, 100, 0, 4, 0, 0, 0, e, l);
        chk(e == 150, "R8 next window clean", e, 150);

        // R9 inputs changed after close
        feed(6, 700, 300, 2, 4, 0, 1, 0, e, l);
        chk(e == 650, "R9 latched thresh/span", e, 650);

        // R4 long mixed window
        feed(1000, 40000, 60000, 337, 663, 0, 0, 0, e, l);
        chk(e == exp_est(40000, 60000, 337, 663), "R4 long window", e,
            exp_est(40000, 60000, 337, 663));

        // R10 reset during divide
        window_len = 16'd2; thresh_mv = 16'd800; span_mv = 16'd100;
        @(negedge clk); sample_en = 1'b1; cmp_bit = 1'b1;
        @(negedge clk); sample_en = 1'b1; cmp_bit = 1'b0;
        @(negedge clk); sample_en = 1'b0;
        repeat (10) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        begin
            bit seen = 0;
            for (int k = 0; k < 60; k++) begin
                @(negedge clk);
                if (est_valid) seen = 1;
            end
            chk(!seen, "R10 no valid after abort", int'(seen), 0);
            chk(est_mv == '0, "R10 est cleared", int'(est_mv), 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule